// File: doc/BRIEF.md
# Extended-Precision Floating-Point Add/Subtract Unit

This unit adds or subtracts two operands held in an 80-bit internal floating-point layout. Bit 79 is the sign. Bits 78:64 hold a 15-bit exponent with a bias of 16383. Bits 63:0 hold a 64-bit mantissa whose leading one is stored explicitly in bit 63. The exponent value 0x7FFF is reserved for infinity and NaN. A subtraction is carried out as an addition after the sign of the second operand has been inverted. The mantissa of the operand with the smaller exponent is shifted right, with truncation, until its exponent matches the larger one. The two mantissas are then either summed or subtracted as magnitudes. A carry out of the sum is absorbed by shifting right. Any leading zeros that remain are removed by shifting left. Alongside the result the unit reports two flags: one for a denormal input and one for overflow to infinity. Rounding control, NaN handling and precision control are not part of this block.

An operand pair is accepted through a valid/ready handshake. The work is then done by a small state machine with these states:
- ST_IDLE: ready, waiting for operands.
- ST_ALIGN: exponent compare and mantissa alignment.
- ST_COMBINE: mantissa add or subtract, plus carry and overflow handling.
- ST_NORM: leading-zero normalisation into the result register.
- ST_DONE: result presented.

The transitions are:
- ST_IDLE→ST_ALIGN when operands are accepted.
- ST_ALIGN→ST_COMBINE, ST_COMBINE→ST_NORM and ST_NORM→ST_DONE unconditionally.
- ST_DONE→ST_IDLE unconditionally.

Top module: `fpx_adder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `out_result` and both flags are 0.
- R2: An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until the result has been shown. `out_valid` is 1 for exactly one cycle, the fourth cycle after acceptance. The result and flags keep their values until the next result is produced, and operands offered while the unit is busy are ignored.
- R3: Alignment takes the larger exponent as the working exponent. The other mantissa is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of 64 or more contributes zero.
- R4: When the effective signs are the same, the aligned mantissas are added and the result keeps the common sign. This includes two equal-signed zeros, whose result is a zero of that sign.
- R5: When the effective signs differ, the smaller aligned mantissa is subtracted from the larger one, and the result takes the sign of the larger. If the two are exactly equal, the result is positive zero (all 80 bits 0).
- R6: When `op_sub` is 1, the result is A minus B. This is obtained by inverting the sign bit (bit 79) of B before the addition.
- R7: A carry out of bit 63 of the mantissa sum shifts the sum right by one, leaving bit 63 set, and increments the working exponent.
- R8: A carry while the working exponent is at least 0x7FFE returns infinity and sets `out_overflow` to 1. Infinity here means the computed sign, exponent 0x7FFF and mantissa 0x8000_0000_0000_0000. In every other case `out_overflow` is 0.
- R9: `out_denormal` is 1 exactly when bit 63 of either input mantissa is 0.
- R10: A result without a carry is shifted left by its leading-zero count, and that count is subtracted from the exponent. If the count exceeds the exponent, the shift is limited to the exponent and the exponent becomes 0.
- R11: A zero mantissa without a carry gives exponent 0 and mantissa 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Unit is idle and can accept operands |
| op_a | input | 80 | First operand |
| op_b | input | 80 | Second operand |
| op_sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| out_valid | output | 1 | One-cycle pulse: result is new |
| out_result | output | 80 | Registered sum or difference |
| out_denormal | output | 1 | An input lacked its explicit leading one |
| out_overflow | output | 1 | Carry at the top exponent produced infinity |

## Verification
The bench aims at the cases where sign and magnitude logic usually goes wrong. Two equal magnitudes of opposite sign must give +0; a unit that copies the first sign would return -0. A result smaller than the first operand needs a leading-zero shift; without it the mantissa comes back unnormalised with a stale exponent. Alignment differences of exactly 63 and exactly 64 are tested; a barrel shift that wraps its amount would bring the tiny operand back in full. Two more cases complete the set. A carry at exponent 0x7FFE must produce infinity with the overflow flag, while one at 0x7FFD must only bump the exponent. A tiny difference near exponent 0 must clamp into a denormal instead of wrapping the exponent around.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned EXP_W  = 15;
    localparam int unsigned MAN_W  = 64;
    localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
    localparam int unsigned LZ_W   = $clog2(MAN_W) + 1;

    localparam logic [EXP_W-1:0] EXP_ALL1   = '1;
    localparam logic [EXP_W-1:0] EXP_TOPFIN = EXP_ALL1 - EXP_W'(1);
    localparam logic [MAN_W-1:0] MAN_LEAD   = {1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fpx_t;

    typedef struct packed {
        logic             sa;
        logic             sb;
        logic [EXP_W-1:0] emax;
        logic [MAN_W-1:0] ma;
        logic [MAN_W-1:0] mb;
        logic             den;
    } fpx_aligned_t;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
        logic             renorm;
        logic             ovf;
        logic             den;
    } fpx_comb_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALIGN   = 3'd1,
        ST_COMBINE = 3'd2,
        ST_NORM    = 3'd3,
        ST_DONE    = 3'd4
    } fpx_state_e;

endpackage

// File: rtl/fpx_align.sv
module fpx_align
    import fpx_pkg::*;
(
    input  fpx_t         a_i,
    input  fpx_t         b_i,
    input  logic         sub_i,
    output fpx_aligned_t al_o
);

    localparam logic [EXP_W-1:0] SHIFT_LIMIT = EXP_W'(MAN_W);

    logic             a_big;
    logic [EXP_W-1:0] diff;

    function automatic logic [MAN_W-1:0] trunc_shr(input logic [MAN_W-1:0] m,
                                                   input logic [EXP_W-1:0] d);
        if (d >= SHIFT_LIMIT) begin
            return '0;
        end
        return m >> d;
    endfunction

    always_comb begin
        a_big      = (a_i.exp >= b_i.exp);
        diff       = a_big ? (a_i.exp - b_i.exp) : (b_i.exp - a_i.exp);
        al_o.sa    = a_i.sgn;
        al_o.sb    = b_i.sgn ^ sub_i;
        al_o.emax  = a_big ? a_i.exp : b_i.exp;
        al_o.ma    = a_big ? a_i.man : trunc_shr(a_i.man, diff);
        al_o.mb    = a_big ? trunc_shr(b_i.man, diff) : b_i.man;
        al_o.den   = ~a_i.man[MAN_W-1] | ~b_i.man[MAN_W-1];
    end

endmodule

// File: rtl/fpx_combine.sv
module fpx_combine
    import fpx_pkg::*;
(
    input  fpx_aligned_t al_i,
    output fpx_comb_t    cb_o
);

    logic [MAN_W:0] sum;
    logic           sgn;

    always_comb begin
        if (al_i.sa == al_i.sb) begin
            sum = {1'b0, al_i.ma} + {1'b0, al_i.mb};
            sgn = al_i.sa;
        end else if (al_i.ma > al_i.mb) begin
            sum = {1'b0, al_i.ma - al_i.mb};
            sgn = al_i.sa;
        end else if (al_i.ma < al_i.mb) begin
            sum = {1'b0, al_i.mb - al_i.ma};
            sgn = al_i.sb;
        end else begin
            sum = '0;
            sgn = 1'b0;
        end
    end

    always_comb begin
        cb_o.sgn = sgn;
        cb_o.den = al_i.den;
        if (sum[MAN_W]) begin
            cb_o.renorm = 1'b0;
            if (al_i.emax >= EXP_TOPFIN) begin
                cb_o.exp = EXP_ALL1;
                cb_o.man = MAN_LEAD;
                cb_o.ovf = 1'b1;
            end else begin
                cb_o.exp = al_i.emax + EXP_W'(1);
                cb_o.man = sum[MAN_W:1];
                cb_o.ovf = 1'b0;
            end
        end else begin
            cb_o.renorm = 1'b1;
            cb_o.exp    = al_i.emax;
            cb_o.man    = sum[MAN_W-1:0];
            cb_o.ovf    = 1'b0;
        end
    end

endmodule

// File: rtl/fpx_normalize.sv
module fpx_normalize
    import fpx_pkg::*;
(
    input  fpx_comb_t cb_i,
    output fpx_t      res_o
);

    logic [LZ_W-1:0]  lz;
    logic [EXP_W-1:0] lz_e;

    always_comb begin
        lz = LZ_W'(MAN_W);
        for (int i = 0; i < MAN_W; i++) begin
            if (cb_i.man[i]) begin
                lz = LZ_W'(MAN_W - 1 - i);
            end
        end
        lz_e = EXP_W'(lz);
    end

    always_comb begin
        res_o.sgn = cb_i.sgn;
        if (!cb_i.renorm) begin
            res_o.exp = cb_i.exp;
            res_o.man = cb_i.man;
        end else if (cb_i.man == '0) begin
            res_o.exp = '0;
            res_o.man = '0;
        end else if (lz_e <= cb_i.exp) begin
            res_o.exp = cb_i.exp - lz_e;
            res_o.man = cb_i.man << lz;
        end else begin
            res_o.exp = '0;
            res_o.man = cb_i.man << cb_i.exp;
        end
    end

endmodule

// File: rtl/fpx_adder.sv
module fpx_adder
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_denormal,
    output logic              out_overflow
);

    fpx_state_e   state_q;
    fpx_state_e   state_d;
    fpx_t         a_q;
    fpx_t         b_q;
    logic         sub_q;
    fpx_aligned_t al_d;
    fpx_aligned_t al_q;
    fpx_comb_t    cb_d;
    fpx_comb_t    cb_q;
    fpx_t         res_d;
    fpx_t         res_q;
    logic         den_q;
    logic         ovf_q;
    logic         accept;

    assign accept = in_valid && (state_q == ST_IDLE);

    fpx_align u_align (
        .a_i   (a_q),
        .b_i   (b_q),
        .sub_i (sub_q),
        .al_o  (al_d)
    );

    fpx_combine u_combine (
        .al_i (al_q),
        .cb_o (cb_d)
    );

    fpx_normalize u_normalize (
        .cb_i  (cb_q),
        .res_o (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ALIGN;
            ST_ALIGN:   state_d = ST_COMBINE;
            ST_COMBINE: state_d = ST_NORM;
            ST_NORM:    state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    in_ready  = 1'b1;
            ST_DONE:    out_valid = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sub_q <= 1'b0;
            al_q  <= '0;
            cb_q  <= '0;
            res_q <= '0;
            den_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        a_q   <= op_a;
                        b_q   <= op_b;
                        sub_q <= op_sub;
                    end
                end
                ST_ALIGN:   al_q <= al_d;
                ST_COMBINE: cb_q <= cb_d;
                ST_NORM: begin
                    res_q <= res_d;
                    den_q <= cb_q.den;
                    ovf_q <= cb_q.ovf;
                end
                default: ;
            endcase
        end
    end

    assign out_result   = res_q;
    assign out_denormal = den_q;
    assign out_overflow = ovf_q;

endmodule

// File: rtl/fpx_adder_chk.sv
module fpx_adder_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_overflow
);

    fpx_t r;
    assign r = out_result;

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##4 out_valid);

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(out_result));

    p_not_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> (r.exp == EXP_ALL1 && r.man == MAN_LEAD));

    p_lead_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r.exp != '0 && r.exp != EXP_ALL1) |-> r.man[MAN_W-1]);

endmodule

bind fpx_adder fpx_adder_chk u_fpx_adder_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_overflow (out_overflow)
);

// File: tb/fpx_adder_tb.sv
`timescale 1ns/1ps
module fpx_adder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [79:0] op_a = '0;
    logic [79:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic        out_valid;
    logic [79:0] out_result;
    logic        out_denormal;
    logic        out_overflow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fpx_adder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .op_a         (op_a),
        .op_b         (op_b),
        .op_sub       (op_sub),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_denormal (out_denormal),
        .out_overflow (out_overflow)
    );

    localparam logic [63:0] LEAD = 64'h8000_0000_0000_0000;

    function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
        return {s, e, m};
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issues one operation, checks the R2 latency, the result and both flags.
    task automatic run_op(input string req, input logic [79:0] a, input logic [79:0] b,
                          input logic sub, input logic [79:0] exp_res,
                          input logic exp_den, input logic exp_ovf);
        int n;
        @(negedge clk);
        chk("R2 ready before issue", {79'd0, in_ready}, 80'd1);
        op_a = a; op_b = b; op_sub = sub; in_valid = 1'b1;
        @(posedge clk);
        n = 0;
        while (n < 10) begin
            @(negedge clk);
            in_valid = 1'b0;
            n++;
            if (out_valid) break;
        end
        chk("R2 latency", 80'(n), 80'd4);
        chk(req, out_result, exp_res);
        chk({req, " denormal flag R9"}, {79'd0, out_denormal}, {79'd0, exp_den});
        chk({req, " overflow flag R8"}, {79'd0, out_overflow}, {79'd0, exp_ovf});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 out_valid", {79'd0, out_valid}, 80'd0);
        chk("R1 in_ready", {79'd0, in_ready}, 80'd1);
        chk("R1 result", out_result, 80'd0);
        chk("R1 flags", {78'd0, out_denormal, out_overflow}, 80'd0);
    endtask

    task automatic t_same_sign;
        run_op("R7 1+1", mk(0,15'h3FFF,LEAD), mk(0,15'h3FFF,LEAD), 0, mk(0,15'h4000,LEAD), 0, 0);
        run_op("R4 1+0.25", mk(0,15'h3FFF,LEAD), mk(0,15'h3FFD,LEAD), 0,
               mk(0,15'h3FFF,64'hA000_0000_0000_0000), 0, 0);
        run_op("R3 0.25+1 swapped", mk(0,15'h3FFD,LEAD), mk(0,15'h3FFF,LEAD), 0,
               mk(0,15'h3FFF,64'hA000_0000_0000_0000), 0, 0);
        run_op("R4 negative sum", mk(1,15'h3FFF,LEAD), mk(1,15'h3FFD,LEAD), 0,
               mk(1,15'h3FFF,64'hA000_0000_0000_0000), 0, 0);
    endtask

    task automatic t_subtract;
        run_op("R6 3-1", mk(0,15'h4000,64'hC000_0000_0000_0000), mk(0,15'h3FFF,LEAD), 1,
               mk(0,15'h4000,LEAD), 0, 0);
        run_op("R5 1-3 negative", mk(0,15'h3FFF,LEAD), mk(0,15'h4000,64'hC000_0000_0000_0000), 1,
               mk(1,15'h4000,LEAD), 0, 0);
    endtask

    task automatic t_tie;
        run_op("R5 1-1 positive zero", mk(0,15'h3FFF,LEAD), mk(0,15'h3FFF,LEAD), 1, 80'd0, 0, 0);
        run_op("R5 -1+1 positive zero", mk(1,15'h3FFF,LEAD), mk(0,15'h3FFF,LEAD), 0, 80'd0, 0, 0);
    endtask

    task automatic t_norm;
        run_op("R10 1-0.75", mk(0,15'h3FFF,LEAD), mk(0,15'h3FFE,64'hC000_0000_0000_0000), 1,
               mk(0,15'h3FFD,LEAD), 0, 0);
        run_op("R10 clamp to denormal", mk(0,15'h0002,LEAD), mk(0,15'h0002,64'h7000_0000_0000_0000), 1,
               mk(0,15'h0000,64'h4000_0000_0000_0000), 1, 0);
    endtask

    task automatic t_shift_edges;
        run_op("R3 shift 63 keeps lsb", mk(0,15'h3FFF,LEAD), mk(0,15'h3FC0,LEAD), 0,
               mk(0,15'h3FFF,64'h8000_0000_0000_0001), 0, 0);
        run_op("R3 shift 64 drops", mk(0,15'h3FFF,LEAD), mk(0,15'h3FBF,64'hFFFF_FFFF_FFFF_FFFF), 0,
               mk(0,15'h3FFF,LEAD), 0, 0);
    endtask

    task automatic t_overflow;
        run_op("R8 max+max to inf", mk(0,15'h7FFE,LEAD), mk(0,15'h7FFE,LEAD), 0, mk(0,15'h7FFF,LEAD), 0, 1);
        run_op("R8 negative inf", mk(1,15'h7FFE,LEAD), mk(0,15'h7FFE,LEAD), 1, mk(1,15'h7FFF,LEAD), 0, 1);
        run_op("R7 carry below top", mk(0,15'h7FFD,64'hC000_0000_0000_0000),
               mk(0,15'h7FFD,64'hC000_0000_0000_0000), 0, mk(0,15'h7FFE,64'hC000_0000_0000_0000), 0, 0);
    endtask

    task automatic t_denormal;
        run_op("R9 two tiny denormals", mk(0,15'h0000,64'd1), mk(0,15'h0000,64'd1), 0,
               mk(0,15'h0000,64'd2), 1, 0);
        run_op("R11 -0 + -0", mk(1,15'h0000,64'd0), mk(1,15'h0000,64'd0), 0, mk(1,15'h0000,64'd0), 1, 0);
        run_op("R9 one unnormal input", mk(0,15'h3FFF,LEAD), mk(0,15'h3FFF,64'h4000_0000_0000_0000), 0,
               mk(0,15'h3FFF,64'hC000_0000_0000_0000), 1, 0);
    endtask

    // R2: operands offered while busy are ignored; result held afterwards.
    task automatic t_busy;
        logic [79:0] first_res;
        first_res = mk(0,15'h4000,LEAD);
        @(negedge clk);
        op_a = mk(0,15'h3FFF,LEAD); op_b = mk(0,15'h3FFF,LEAD); op_sub = 0; in_valid = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R2 ready low while busy", {79'd0, in_ready}, 80'd0);
            op_a = mk(0,15'h1234,LEAD); op_b = mk(1,15'h1000,LEAD); op_sub = 1;
        end
        @(negedge clk);
        chk("R2 valid in fourth cycle", {79'd0, out_valid}, 80'd1);
        chk("R2 busy operands ignored", out_result, first_res);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 valid single cycle", {79'd0, out_valid}, 80'd0);
        chk("R2 result held", out_result, first_res);
        chk("R2 ready again", {79'd0, in_ready}, 80'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same_sign();
        t_subtract();
        t_tie();
        t_norm();
        t_shift_edges();
        t_overflow();
        t_denormal();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule